// File: doc/BRIEF.md
# DRAM refresh and power-up sequencer

This block brings an asynchronous DRAM with 2,048 rows to a usable state after power-up and then keeps its contents alive. Out of reset it holds both strobes high for a fixed pause, then runs a burst of wake-up strobe cycles on its own. Only then does it assert `ready`, which tells the access controller that it may use the memory bus.

In normal operation an interval timer produces one refresh request per row period. Requests accumulate in a pending counter. While any request is pending the block raises `req`. When the controller answers with `grant`, the block owns the bus and runs one refresh cycle per pending request. The cycle is either CAS-before-RAS, where the DRAM's internal counter supplies the row, or RAS-only, where the block's own wrapping row counter drives the address bus. `mode_ras_only` selects the kind, and it is sampled when each cycle starts. If grants are withheld so long that the pending count passes a limit, the refresh deadline counts as missed: `deadline_miss` rises and `ready` falls. The next grant then triggers a full wake-up burst instead of single cycles.

The state machine has six states. `S_PAUSE` is the power-up wait. `S_IDLE` has no work. `S_REQ` waits for grant. `S_LEAD` is the set-up phase: CAS is low in CBR mode, or the address is driven in RAS-only mode. `S_ACT` holds RAS low. `S_PRE` is precharge with both strobes high.

The transitions are:
- `S_PAUSE` to `S_LEAD` when the pause expires, starting the wake-up burst.
- `S_IDLE` to `S_REQ` when pending is non-zero.
- `S_REQ` to `S_LEAD` on grant.
- `S_LEAD` to `S_ACT` and `S_ACT` to `S_PRE` when their timers expire.
- `S_PRE` to `S_LEAD` when more burst cycles remain.
- `S_PRE` to `S_IDLE` otherwise.

Top module: `rfsh_seq`

## Requirements
- R1: While reset is held, and for PAUSE_CYC clock cycles after reset is released, `ras_n` and `cas_n` stay high and `req`, `ready`, `deadline_miss` and `addr_oe` stay low.
- R2: After the pause, exactly WAKE_CNT strobe cycles run without any grant. `ready` rises PAUSE_CYC + WAKE_CNT*(T_CSR+T_RAS+T_RP) cycles after reset release.
- R3: In CBR mode `addr_oe` is 0. `cas_n` falls exactly T_CSR cycles before `ras_n` falls, stays low for the whole RAS-low interval, and is high again in the cycle where `ras_n` rises.
- R4: Every RAS-low pulse lasts exactly T_RAS cycles. Between two RAS-low pulses `ras_n` is high for at least T_RP+T_CSR cycles.
- R5: With `grant` held high and no missed deadline, successive refresh cycles start exactly INTERVAL_CYC cycles apart.
- R6: While `grant` is low, no new refresh cycle starts and `req` stays high once a request is pending. When `grant` returns, exactly one refresh cycle runs for each pending request, as long as the count never exceeded MISS_LIM.
- R7: When the pending count exceeds MISS_LIM, `deadline_miss` is 1 and `ready` is 0. On the next grant exactly WAKE_CNT cycles run. After that `deadline_miss` is 0 and `ready` is 1.
- R8: In RAS-only mode `cas_n` stays high and `addr_oe` is 1 while `ras_n` is low. `addr` holds the row counter, which starts at 0 after reset and advances by one after every RAS-only cycle, wrapping from ROWS-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_ras_only | input | 1 | 1 selects RAS-only refresh, 0 selects CAS-before-RAS; sampled at each cycle start |
| grant | input | 1 | Bus granted by the access controller |
| req | output | 1 | Bus wanted or owned by the sequencer |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| addr_oe | output | 1 | Sequencer drives the row address bus |
| addr | output | ROW_W | Row address for RAS-only refresh |
| ready | output | 1 | Memory initialised and deadline met |
| deadline_miss | output | 1 | Pending requests exceeded the limit |

## Verification
The bench builds the block with a 20-cycle pause, a 40-cycle refresh interval, 8 rows, strobe timings of 1/3/2 cycles and a miss limit of 2. At these values the whole power-up sequence, several refresh periods, both kinds of grant withholding and more than a full wrap of the row counter all fit into a few thousand cycles. Every strobe edge can therefore be measured against numbers computed from those parameters. Withholding grant for exactly two intervals and then for four places the pending count just below and just above the miss limit.

// File: rtl/rfsh_seq_pkg.sv
package rfsh_seq_pkg;
    typedef enum logic [2:0] {
        S_PAUSE,
        S_IDLE,
        S_REQ,
        S_LEAD,
        S_ACT,
        S_PRE
    } rfsh_state_t;
endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
    parameter int INTERVAL = 3125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int IW = $clog2(INTERVAL + 1);

    logic [IW-1:0] cnt;

    assign tick = en && (cnt == IW'(INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (tick)   cnt <= '0;
        else if (en)     cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rfsh_pending_ctr.sv
module rfsh_pending_ctr #(
    parameter int MISS_LIM = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    input  logic clr,
    output logic nonzero,
    output logic miss
);
    localparam int PW = $clog2(MISS_LIM + 2) + 1;

    logic [PW-1:0] cnt;

    assign nonzero = (cnt != '0);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   if (cnt != '1) cnt <= cnt + 1'b1;
                2'b01:   if (cnt != '0) cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr)            miss <= 1'b0;
        else if (cnt > PW'(MISS_LIM)) miss <= 1'b1;
    end

    // R7: once raised, the miss flag holds until the recovery burst clears it
    a_r7_miss_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (miss && !clr) |=> miss);
endmodule

// File: rtl/rfsh_row_ctr.sv
module rfsh_row_ctr #(
    parameter int ROWS = 2048
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     step,
    output logic [$clog2(ROWS)-1:0]  row
);
    localparam int RW = $clog2(ROWS);

    always_ff @(posedge clk) begin
        if (!rst_n)       row <= '0;
        else if (step)    row <= (row == RW'(ROWS - 1)) ? '0 : row + 1'b1;
    end

    // R8: row counter wraps from the last row back to zero
    a_r8_row_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step && row == RW'(ROWS - 1)) |=> (row == '0));
endmodule

// File: rtl/rfsh_seq.sv
module rfsh_seq
    import rfsh_seq_pkg::*;
#(
    parameter int PAUSE_CYC    = 40000,
    parameter int WAKE_CNT     = 8,
    parameter int INTERVAL_CYC = 3125,
    parameter int ROWS         = 2048,
    parameter int T_CSR        = 1,
    parameter int T_RAS        = 10,
    parameter int T_RP         = 6,
    parameter int MISS_LIM     = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mode_ras_only,
    input  logic                     grant,
    output logic                     req,
    output logic                     ras_n,
    output logic                     cas_n,
    output logic                     addr_oe,
    output logic [$clog2(ROWS)-1:0]  addr,
    output logic                     ready,
    output logic                     deadline_miss
);
    localparam int ROW_W = $clog2(ROWS);
    localparam int TMR_W = $clog2(PAUSE_CYC + T_CSR + T_RAS + T_RP + 1);
    localparam int WK_W  = $clog2(WAKE_CNT + 1);

    rfsh_state_t      state, state_nxt;
    logic [TMR_W-1:0] tmr, dur;
    logic [WK_W-1:0]  wk;
    logic             in_burst, mode_q;
    logic             tmr_last, cyc_done, burst_done;
    logic             tick, pend_nz, miss;
    logic [ROW_W-1:0] row;

    always_comb begin
        unique case (state)
            S_PAUSE: dur = TMR_W'(PAUSE_CYC);
            S_LEAD:  dur = TMR_W'(T_CSR);
            S_ACT:   dur = TMR_W'(T_RAS);
            S_PRE:   dur = TMR_W'(T_RP);
            default: dur = TMR_W'(1);
        endcase
    end

    assign tmr_last   = (tmr == dur - 1'b1);
    assign cyc_done   = (state == S_PRE) && tmr_last;
    assign burst_done = cyc_done && in_burst && (wk == WK_W'(WAKE_CNT - 1));

    rfsh_interval_timer #(.INTERVAL(INTERVAL_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (state != S_PAUSE),
        .tick  (tick)
    );

    rfsh_pending_ctr #(.MISS_LIM(MISS_LIM)) u_pending (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (tick),
        .dec     (cyc_done && !in_burst),
        .clr     (burst_done),
        .nonzero (pend_nz),
        .miss    (miss)
    );

    rfsh_row_ctr #(.ROWS(ROWS)) u_row (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (cyc_done && mode_q),
        .row   (row)
    );

    always_comb begin
        state_nxt = state;
        unique case (state)
            S_PAUSE: if (tmr_last) state_nxt = S_LEAD;
            S_IDLE:  if (pend_nz)  state_nxt = S_REQ;
            S_REQ:   if (grant)    state_nxt = S_LEAD;
            S_LEAD:  if (tmr_last) state_nxt = S_ACT;
            S_ACT:   if (tmr_last) state_nxt = S_PRE;
            S_PRE:   if (tmr_last) state_nxt = (in_burst && !burst_done) ? S_LEAD : S_IDLE;
            default: state_nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_PAUSE;
            tmr      <= '0;
            wk       <= '0;
            in_burst <= 1'b1;
            mode_q   <= 1'b0;
        end else begin
            state <= state_nxt;
            tmr   <= (state_nxt != state) ? '0 : tmr + 1'b1;
            if (state_nxt == S_LEAD && state != S_LEAD)
                mode_q <= mode_ras_only;
            if (state == S_REQ && grant && miss)
                in_burst <= 1'b1;
            else if (burst_done)
                in_burst <= 1'b0;
            if (cyc_done && in_burst)
                wk <= burst_done ? '0 : wk + 1'b1;
        end
    end

    always_comb begin
        ras_n         = (state != S_ACT);
        cas_n         = !(!mode_q && (state == S_LEAD || state == S_ACT));
        addr_oe       = mode_q && (state == S_LEAD || state == S_ACT);
        addr          = row;
        req           = (state == S_REQ) || (state == S_LEAD) ||
                        (state == S_ACT) || (state == S_PRE);
        ready         = !in_burst && !miss;
        deadline_miss = miss;
    end

    // R3: in CBR mode the column strobe was already low when the row strobe fell
    a_r3_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !addr_oe) |-> $past(!cas_n));

    // R8: column strobe stays high during a RAS-only cycle
    a_r8_rasonly_cas_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && addr_oe) |-> cas_n);

    // R8: row address does not move while the row strobe is low
    a_r8_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && $past(!ras_n) && addr_oe) |-> $stable(addr));

    // R6: no row strobe activity follows a cycle spent waiting without grant
    a_r6_wait_for_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_REQ && !grant) |=> (ras_n && req));
endmodule

// File: tb/rfsh_seq_bench.sv
module rfsh_seq_bench;
    localparam int PAUSE  = 20;
    localparam int WAKE   = 8;
    localparam int INTV   = 40;
    localparam int ROWS   = 8;
    localparam int TCSR   = 1;
    localparam int TRAS   = 3;
    localparam int TRP    = 2;
    localparam int MLIM   = 2;
    localparam int CYCLEN = TCSR + TRAS + TRP;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_ras_only = 1'b0;
    logic grant = 1'b1;
    logic req, ras_n, cas_n, addr_oe, ready, deadline_miss;
    logic [$clog2(ROWS)-1:0] addr;

    always #2.5 clk = ~clk;

    rfsh_seq #(
        .PAUSE_CYC(PAUSE), .WAKE_CNT(WAKE), .INTERVAL_CYC(INTV), .ROWS(ROWS),
        .T_CSR(TCSR), .T_RAS(TRAS), .T_RP(TRP), .MISS_LIM(MLIM)
    ) u_rfsh_seq (
        .clk(clk), .rst_n(rst_n), .mode_ras_only(mode_ras_only), .grant(grant),
        .req(req), .ras_n(ras_n), .cas_n(cas_n), .addr_oe(addr_oe), .addr(addr),
        .ready(ready), .deadline_miss(deadline_miss)
    );

    int total = 0;
    int bad = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // edge monitor, samples at the falling clock edge
    int cyc = 0, falls = 0, ro_cycles = 0, exp_row = 0;
    int low_run = 0, high_run = 0, cas_run = 0, last_fall = 0;
    bit prev_ras = 1, have_fall = 0, space_on = 0, have_sp = 0, cur_ro = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            cyc = 0;
        end else begin
            cyc++;
            cas_run = cas_n ? 0 : cas_run + 1;
            if (!ras_n && prev_ras) begin
                falls++;
                cur_ro = addr_oe;
                if (!addr_oe) chk(cas_run == TCSR + 1, "R3 cas lead", cas_run, TCSR + 1);
                if (have_fall) chk(high_run >= TRP + TCSR, "R4 ras high gap", high_run, TRP + TCSR);
                if (space_on && have_sp) chk(cyc - last_fall == INTV, "R5 spacing", cyc - last_fall, INTV);
                last_fall = cyc;
                have_sp = space_on;
                have_fall = 1;
                low_run = 1;
            end else if (!ras_n) begin
                low_run++;
            end
            if (!ras_n) begin
                if (addr_oe) begin
                    chk(cas_n == 1'b1, "R8 cas high", int'(cas_n), 1);
                    chk(int'(addr) == exp_row, "R8 row address", int'(addr), exp_row);
                end else begin
                    chk(cas_n == 1'b0, "R3 cas low during ras", int'(cas_n), 0);
                end
            end
            if (ras_n && !prev_ras) begin
                chk(low_run == TRAS, "R4 ras width", low_run, TRAS);
                chk(cas_n == 1'b1, "R3 cas rises with ras", int'(cas_n), 1);
                if (cur_ro) begin
                    exp_row = (exp_row + 1) % ROWS;
                    ro_cycles++;
                end
                high_run = 1;
            end else if (ras_n) begin
                high_run++;
            end
            prev_ras = ras_n;
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wait_fall();
        int f0 = falls;
        for (int i = 0; i < 400 && falls == f0; i++) step();
    endtask

    initial begin
        int k, f0;
        bit quiet;
        repeat (3) step();
        chk(ras_n && cas_n && !req && !ready && !deadline_miss && !addr_oe,
            "R1 reset outputs", {ras_n, cas_n, req, ready, deadline_miss, addr_oe}, 6'b110000);
        rst_n = 1'b1;

        // R1: quiet pause
        quiet = 1;
        for (int i = 1; i < PAUSE; i++) begin
            step();
            if (!(ras_n && cas_n && !req && !ready && !addr_oe)) quiet = 0;
        end
        chk(quiet, "R1 pause quiet", int'(quiet), 1);

        // R2: wake-up burst and ready timing
        k = PAUSE - 1;
        for (int i = 0; i < 1000 && !ready; i++) begin
            step();
            k++;
        end
        chk(k == PAUSE + WAKE * CYCLEN, "R2 ready time", k, PAUSE + WAKE * CYCLEN);
        chk(falls == WAKE, "R2 wake count", falls, WAKE);

        // R5: regular spacing with grant held
        space_on = 1;
        for (int i = 0; i < 5; i++) wait_fall();
        space_on = 0;
        chk(ready && !deadline_miss, "R5 ready during refresh", int'(ready), 1);

        // R6: withhold grant for two intervals
        wait_fall();
        grant = 1'b0;
        f0 = falls;
        repeat (80) step();
        chk(falls == f0, "R6 no cycle without grant", falls, f0);
        chk(req == 1'b1, "R6 req pending", int'(req), 1);
        chk(deadline_miss == 1'b0, "R6 no miss at limit", int'(deadline_miss), 0);
        grant = 1'b1;
        repeat (25) step();
        chk(falls - f0 == 2, "R6 catch-up cycles", falls - f0, 2);

        // R7: withhold grant for four intervals
        wait_fall();
        grant = 1'b0;
        f0 = falls;
        repeat (160) step();
        chk(deadline_miss == 1'b1, "R7 miss flag", int'(deadline_miss), 1);
        chk(ready == 1'b0, "R7 ready dropped", int'(ready), 0);
        chk(falls == f0, "R7 no cycle without grant", falls, f0);
        grant = 1'b1;
        for (int i = 0; i < 300 && !ready; i++) step();
        chk(falls - f0 == WAKE, "R7 recovery burst", falls - f0, WAKE);
        chk(ready && !deadline_miss, "R7 recovered", {ready, deadline_miss}, 2'b10);

        // R8: RAS-only mode across a wrap of the row counter
        wait_fall();
        mode_ras_only = 1'b1;
        for (int i = 0; i < 1000 && ro_cycles < ROWS + 3; i++) step();
        chk(ro_cycles >= ROWS + 3, "R8 wrap reached", ro_cycles, ROWS + 3);
        chk(exp_row == (ROWS + 3) % ROWS, "R8 row sequence", exp_row, (ROWS + 3) % ROWS);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule